// File: doc/BRIEF.md
# Segmented Variable-Length Instruction Fetch

This block fetches instructions one byte at a time for a processor whose code segment and instruction pointer are 16-bit registers and whose memory bus carries a 20-bit byte address. Every byte's bus address is the code segment multiplied by sixteen plus the current pointer, wrapped to 20 bits. The first byte read is the opcode. A small lookup gives the instruction's total length, from one to six bytes. The remaining bytes are read in order, the pointer moves past the whole instruction, and a one-cycle valid pulse presents the instruction register and its length.

A `start` pulse in the idle state loads the segment and the initial pointer. After each instruction the block waits until `next` requests the following fetch. When the fetched opcode is the halt code F4h, the block stops, and only reset releases it. Memory uses a request/ready handshake. One byte moves in every cycle where request and ready are both high.

Top module: `ifetch_unit`

## Requirements
- R1: While a request is open, `mem_addr` equals (segment × 16 + pointer) mod 2^20. For example, segment 6020h with pointer 4267h gives 64467h, and segment FFFFh with pointer FFFEh gives 0FFEEh.
- R2: One byte is taken in each cycle where `mem_req` and `mem_rdy` are both high. While `mem_rdy` is low, `mem_req` stays high and `mem_addr` does not change.
- R3: The total length is decided by the opcode byte: B0h–B7h give 2; B8h–BFh give 3; E8h and E9h give 3; EAh gives 5; C7h gives 6; 04h, 0Ch, 24h and 3Ch give 2; F4h and every other code give 1. `ir_len` shows this length while `valid` is high.
- R4: Fetched byte k (k = 0 for the opcode) sits in `ir_bytes[8k+7:8k]` in fetch order, with no word reordering. Lanes past the instruction's length read zero.
- R5: The pointer rises by one after every accepted byte, modulo 2^16. After an instruction, `ip_out` holds the address of the first byte of the next instruction.
- R6: `valid` is high for exactly one cycle. That cycle is the one after the last byte of an instruction is accepted.
- R7: After an instruction completes (other than halt), no request is made until `next` is high. `next` at any other time has no effect.
- R8: `start` loads the segment and the pointer only while idle. At any other time it has no effect.
- R9: Once the halt opcode F4h has been fetched, `halted` stays high and `mem_req` stays low until reset.
- R10: After reset, `mem_req`, `valid`, `halted`, `ip_out` and `ir_bytes` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin fetching from `cs_in:ip_in` (idle only) |
| next | input | 1 | Fetch the following instruction (after completion) |
| cs_in | input | 16 | Code segment value |
| ip_in | input | 16 | Initial instruction pointer |
| mem_req | output | 1 | Byte read request |
| mem_addr | output | 20 | Absolute byte address |
| mem_rdy | input | 1 | Memory accepts the request and returns the byte |
| mem_data | input | 8 | Byte returned by memory |
| ir_bytes | output | 48 | Instruction register, byte 0 in the low lane |
| ir_len | output | 3 | Instruction length in bytes |
| ip_out | output | 16 | Current instruction pointer |
| valid | output | 1 | One-cycle instruction-ready pulse |
| halted | output | 1 | Halt opcode fetched |

## Verification
The assertions check properties that must hold on every cycle. They check that a request and its address hold still across ready stalls, that the pointer steps by one after each accepted byte, that `valid` is a single-cycle pulse, that the halt state is sticky with no requests, that the upper instruction lanes clear when an opcode arrives, and that the looked-up length stays between one and six. Some behaviour can only be shown by the bench's scenarios. These are the actual address arithmetic, including both wrap points; the contents and order of each fetched instruction across the full length table; the final pointer value; and that stray `start` and `next` pulses during a fetch change nothing. The bench's reference model follows these on every clock while memory stalls at random.

// File: rtl/ifetch_pkg.sv
package ifetch_pkg;

   typedef enum logic [2:0] {
      FS_IDLE,
      FS_OPC,
      FS_REST,
      FS_DONE,
      FS_HALT
   } fstate_t;

   // Total instruction length selected by the leading byte
   function automatic int unsigned opcode_len(input logic [7:0] op);
      int unsigned n;
      n = 1;
      if (op[7:3] == 5'b10110)
         n = 2;
      else if (op[7:3] == 5'b10111)
         n = 3;
      else begin
         case (op)
            8'hE8, 8'hE9:                n = 3;
            8'hEA:                       n = 5;
            8'hC7:                       n = 6;
            8'h04, 8'h0C, 8'h24, 8'h3C:  n = 2;
            default:                     n = 1;
         endcase
      end
      return n;
   endfunction

endpackage

// File: rtl/ifetch_agen.sv
module ifetch_agen #(
   parameter int SEG_W  = 16,
   parameter int OFS_W  = 16,
   parameter int SHIFT  = 4,
   parameter int ADDR_W = 20
) (
   input  logic [SEG_W-1:0]  seg,
   input  logic [OFS_W-1:0]  ofs,
   output logic [ADDR_W-1:0] addr
);
   localparam int BASE_W = SEG_W + SHIFT;
   localparam int FULL_W = ((BASE_W > OFS_W) ? BASE_W : OFS_W) + 1;

   logic [FULL_W-1:0] sum;

   assign sum = (FULL_W'(seg) << SHIFT) + FULL_W'(ofs);

   generate
      if (ADDR_W <= FULL_W) begin : g_trunc
         assign addr = sum[ADDR_W-1:0];
      end else begin : g_extend
         assign addr = {{(ADDR_W-FULL_W){1'b0}}, sum};
      end
   endgenerate

   initial begin
      assert (SHIFT >= 0 && ADDR_W > 0 && SEG_W > 0 && OFS_W > 0)
         else $error("ifetch_agen: bad widths");
   end
endmodule

// File: rtl/ifetch_len_dec.sv
module ifetch_len_dec #(
   parameter int MAX_LEN = 6,
   parameter int LEN_W   = 3
) (
   input  logic [7:0]       opcode,
   output logic [LEN_W-1:0] len
);
   import ifetch_pkg::*;

   int unsigned raw;

   always_comb raw = opcode_len(opcode);

   generate
      if (MAX_LEN >= 6) begin : g_full
         assign len = LEN_W'(raw);
      end else begin : g_clamp
         assign len = (raw > MAX_LEN) ? LEN_W'(MAX_LEN) : LEN_W'(raw);
      end
   endgenerate

   // R3
   always_comb begin
      len_range_chk: assert (len >= 1 && len <= MAX_LEN);
   end

   initial begin
      assert (MAX_LEN >= 1 && (1 << LEN_W) > MAX_LEN)
         else $error("ifetch_len_dec: LEN_W too small");
   end
endmodule

// File: rtl/ifetch_ir_reg.sv
module ifetch_ir_reg #(
   parameter int LANES  = 6,
   parameter int BYTE_W = 8,
   parameter int IDX_W  = 3
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic                    first,
   input  logic [IDX_W-1:0]        wr_idx,
   input  logic [BYTE_W-1:0]       wr_data,
   output logic [LANES*BYTE_W-1:0] ir_flat
);
   generate
      for (genvar k = 0; k < LANES; k++) begin : g_lane
         logic [BYTE_W-1:0] lane_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               lane_q <= '0;
            else if (wr_en && wr_idx == IDX_W'(k))
               lane_q <= wr_data;
            else if (first)
               lane_q <= '0;
         end
         assign ir_flat[k*BYTE_W +: BYTE_W] = lane_q;
      end
   endgenerate

   // R4
   upper_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      first |=> ir_flat[LANES*BYTE_W-1:BYTE_W] == '0);

   initial begin
      assert (LANES >= 2 && (1 << IDX_W) > LANES)
         else $error("ifetch_ir_reg: bad lane configuration");
   end
endmodule

// File: rtl/ifetch_unit.sv
module ifetch_unit #(
   parameter int          SEG_W   = 16,
   parameter int          ADDR_W  = 20,
   parameter int          SHIFT   = 4,
   parameter int          MAX_LEN = 6,
   parameter logic [7:0]  HALT_OP = 8'hF4,
   parameter int          LEN_W   = $clog2(MAX_LEN + 1)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start,
   input  logic                   next,
   input  logic [SEG_W-1:0]       cs_in,
   input  logic [SEG_W-1:0]       ip_in,
   output logic                   mem_req,
   output logic [ADDR_W-1:0]      mem_addr,
   input  logic                   mem_rdy,
   input  logic [7:0]             mem_data,
   output logic [MAX_LEN*8-1:0]   ir_bytes,
   output logic [LEN_W-1:0]       ir_len,
   output logic [SEG_W-1:0]       ip_out,
   output logic                   valid,
   output logic                   halted
);
   import ifetch_pkg::*;

   fstate_t          st_q, st_d;
   logic [SEG_W-1:0] seg_q, ip_q;
   logic [LEN_W-1:0] len_q, cnt_q, dec_len, tgt_len, rcv_cnt;
   logic [7:0]       opc_q, lead_op;
   logic             valid_q, accept, in_opc, last;

   assign mem_req = (st_q == FS_OPC) || (st_q == FS_REST);
   assign accept  = mem_req && mem_rdy;
   assign in_opc  = (st_q == FS_OPC);

   ifetch_len_dec #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_len (
      .opcode (mem_data),
      .len    (dec_len)
   );

   ifetch_agen #(.SEG_W(SEG_W), .OFS_W(SEG_W), .SHIFT(SHIFT), .ADDR_W(ADDR_W)) u_agen (
      .seg  (seg_q),
      .ofs  (ip_q),
      .addr (mem_addr)
   );

   ifetch_ir_reg #(.LANES(MAX_LEN), .BYTE_W(8), .IDX_W(LEN_W)) u_ir (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (accept),
      .first   (accept && in_opc),
      .wr_idx  (rcv_cnt),
      .wr_data (mem_data),
      .ir_flat (ir_bytes)
   );

   assign tgt_len = in_opc ? dec_len : len_q;
   assign rcv_cnt = in_opc ? '0 : cnt_q;
   assign last    = (rcv_cnt + LEN_W'(1)) == tgt_len;
   assign lead_op = in_opc ? mem_data : opc_q;

   always_comb begin
      st_d = st_q;
      case (st_q)
         FS_IDLE: if (start) st_d = FS_OPC;
         FS_OPC, FS_REST: begin
            if (accept) begin
               if (last)
                  st_d = (lead_op == HALT_OP) ? FS_HALT : FS_DONE;
               else
                  st_d = FS_REST;
            end
         end
         FS_DONE: if (next) st_d = FS_OPC;
         FS_HALT: st_d = FS_HALT;
         default: st_d = FS_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= FS_IDLE;
         seg_q   <= '0;
         ip_q    <= '0;
         len_q   <= '0;
         cnt_q   <= '0;
         opc_q   <= '0;
         valid_q <= 1'b0;
      end else begin
         st_q    <= st_d;
         valid_q <= accept && last;
         if (st_q == FS_IDLE && start) begin
            seg_q <= cs_in;
            ip_q  <= ip_in;
         end
         if (accept) begin
            ip_q  <= ip_q + SEG_W'(1);
            cnt_q <= rcv_cnt + LEN_W'(1);
            if (in_opc) begin
               len_q <= dec_len;
               opc_q <= mem_data;
            end
         end
      end
   end

   assign ir_len = len_q;
   assign ip_out = ip_q;
   assign valid  = valid_q;
   assign halted = (st_q == FS_HALT);

   // R2
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_rdy) |=> (mem_req && $stable(mem_addr)));

   // R5
   ip_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> (ip_q == $past(ip_q) + SEG_W'(1)));

   // R6
   valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid |=> !valid);

   // R8
   no_return_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q != FS_IDLE) |=> (st_q != FS_IDLE));

   // R9
   halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> (halted && !mem_req));

   initial begin
      assert (ADDR_W <= SEG_W + SHIFT + 1 && MAX_LEN >= 1)
         else $error("ifetch_unit: unsupported parameter set");
   end
endmodule

// File: tb/test_ifetch_unit.sv
module test_ifetch_unit;
   logic        clk = 1'b0;
   logic        rst_n, start, nxt, mem_rdy;
   logic [15:0] cs_in, ip_in;
   logic [7:0]  mem_data;
   logic        mem_req, valid, halted;
   logic [19:0] mem_addr;
   logic [47:0] ir_bytes;
   logic [2:0]  ir_len;
   logic [15:0] ip_out;

   always #4 clk = ~clk;

   ifetch_unit i_ifetch_unit (
      .clk(clk), .rst_n(rst_n), .start(start), .next(nxt),
      .cs_in(cs_in), .ip_in(ip_in),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdy(mem_rdy), .mem_data(mem_data),
      .ir_bytes(ir_bytes), .ir_len(ir_len), .ip_out(ip_out),
      .valid(valid), .halted(halted)
   );

   logic [7:0] mem [int];
   int checks = 0, errors = 0, cyc = 0;
   bit armed = 0;

   // reference model: 0 idle, 1 opcode, 2 rest, 3 done, 4 halted
   int         mst = 0;
   logic [15:0] mseg = 0, mip = 0;
   int         mlen = 0;
   logic [7:0] mb[$];
   bit         mvalid = 0;
   bit         p_start = 0, p_next = 0, p_rdy = 0;
   logic [7:0] p_data = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic int ref_len(input logic [7:0] op);
      if (op >= 8'hB0 && op <= 8'hB7) return 2;
      if (op >= 8'hB8 && op <= 8'hBF) return 3;
      if (op == 8'hE8 || op == 8'hE9) return 3;
      if (op == 8'hEA) return 5;
      if (op == 8'hC7) return 6;
      if (op == 8'h04 || op == 8'h0C || op == 8'h24 || op == 8'h3C) return 2;
      return 1;
   endfunction

   function automatic logic [7:0] rd(input logic [19:0] a);
      int k = int'(a);
      return mem.exists(k) ? mem[k] : 8'h90;
   endfunction

   task automatic model_finish();
      mvalid = 1;
      mst = (mb[0] == 8'hF4) ? 4 : 3;
   endtask

   always @(negedge clk) begin
      logic [47:0] exp_ir;
      logic [19:0] exp_addr;
      cyc++;
      if (!rst_n) begin
         mst = 0; mip = 0; mseg = 0; mvalid = 0; mb.delete();
         p_start = 0; p_next = 0; p_rdy = 0; p_data = 0;
         // R10
         chk(mem_req == 0, "R10", "mem_req", mem_req, 0);
         chk(valid == 0 && halted == 0, "R10", "valid/halted", {valid, halted}, 0);
         chk(ip_out == 0 && ir_bytes == 0, "R10", "ip/ir", {ip_out, ir_bytes}, 0);
      end else begin
         mvalid = 0;
         case (mst)
            0: if (p_start) begin mseg = cs_in; mip = ip_in; mst = 1; end
            1: if (p_rdy) begin
                  mb.delete(); mb.push_back(p_data);
                  mlen = ref_len(p_data); mip = mip + 16'd1;
                  if (mlen == 1) model_finish(); else mst = 2;
               end
            2: if (p_rdy) begin
                  mb.push_back(p_data); mip = mip + 16'd1;
                  if (mb.size() == mlen) model_finish();
               end
            3: if (p_next) mst = 1;
            default: ;
         endcase
         // R2 R7 R8: request only while the model is fetching
         chk(mem_req == (mst == 1 || mst == 2), "R2", "mem_req", mem_req, (mst == 1 || mst == 2));
         if (mst == 1 || mst == 2) begin
            exp_addr = 20'({mseg, 4'h0}) + 20'(mip);
            chk(mem_addr == exp_addr, "R1", "mem_addr", mem_addr, exp_addr);
         end
         chk(valid == mvalid, "R6", "valid", valid, mvalid);
         chk(halted == (mst == 4), "R9", "halted", halted, (mst == 4));
         chk(ip_out == mip, "R5", "ip_out", ip_out, mip);
         if (mvalid) begin
            exp_ir = '0;
            foreach (mb[k]) exp_ir[k*8 +: 8] = mb[k];
            chk(ir_len == 3'(mlen), "R3", "ir_len", ir_len, mlen);
            chk(ir_bytes == exp_ir, "R4", "ir_bytes", ir_bytes, exp_ir);
         end
         p_rdy   = ($urandom % 4) != 0;
         p_data  = rd(mem_addr);
         p_start = (mst == 0) ? armed : (($urandom % 5) == 0);
         p_next  = (mst == 3) ? (($urandom % 2) == 0) : (($urandom % 6) == 0);
      end
      start    = p_start;
      nxt      = p_next;
      mem_rdy  = p_rdy;
      mem_data = p_data;
   end

   task automatic do_reset();
      armed = 0;
      @(posedge clk); #1 rst_n = 0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
   endtask

   task automatic wait_halt();
      for (int i = 0; i < 4000 && !halted; i++) @(negedge clk);
      repeat (6) @(negedge clk);
   endtask

   task automatic load(input logic [19:0] base, input logic [7:0] b[$]);
      foreach (b[k]) mem[int'(base) + k] = b[k];
   endtask

   initial begin
      rst_n = 0; start = 0; nxt = 0; mem_rdy = 0; mem_data = 0;
      cs_in = 16'h1000; ip_in = 16'h3C08;
      load(20'h13C08, '{8'hB8, 8'h34, 8'h12, 8'h90, 8'hEA, 8'h11, 8'h22, 8'h33, 8'h44,
                        8'hC7, 8'h06, 8'hAA, 8'hBB, 8'hCC, 8'hDD, 8'hB0, 8'h55,
                        8'h0F, 8'hE8, 8'h01, 8'h02, 8'hF4});
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      armed = 1;
      wait_halt();
      // R5 final pointer after 22 bytes; R9 halt reached
      chk(ip_out == 16'h3C1E, "R5", "final ip", ip_out, 16'h3C1E);
      chk(halted == 1 && mem_req == 0, "R9", "halted idle bus", {halted, mem_req}, 2'b10);

      // wrap of both the pointer and the 20-bit sum
      do_reset();
      cs_in = 16'hFFFF; ip_in = 16'hFFFE;
      mem[32'h0FFEE] = 8'hB8; mem[32'h0FFEF] = 8'h77;
      mem[32'hFFFF0] = 8'h66; mem[32'hFFFF1] = 8'hF4;
      armed = 1;
      for (int i = 0; i < 100 && !mem_req; i++) @(negedge clk);
      chk(mem_addr == 20'h0FFEE, "R1", "wrapped address", mem_addr, 20'h0FFEE);
      wait_halt();
      chk(ip_out == 16'h0002, "R5", "wrapped ip", ip_out, 16'h0002);

      // worked example address
      do_reset();
      cs_in = 16'h6020; ip_in = 16'h4267;
      mem[32'h64467] = 8'hF4;
      armed = 1;
      for (int i = 0; i < 100 && !mem_req; i++) @(negedge clk);
      chk(mem_addr == 20'h64467, "R1", "example address", mem_addr, 20'h64467);
      wait_halt();
      chk(ip_out == 16'h4268, "R9", "halt after one byte", ip_out, 16'h4268);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(8 * 150000);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule